// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block holds the per-channel control and status bits of a multi-channel DMA engine with up to 32 channels, together with one global control register. Software reaches it through a simple single-cycle register port. The transfer engine reaches it through per-channel completion and error event inputs. In the other direction, the bank gives the engine its request-enable vector, its arbitration and halt controls, and single-cycle start and done-clear pulses.

Each channel bit can be changed atomically. Software writes a channel number into a dedicated set or clear command byte, so no read-modify-write of a shared bitmask is needed. The bank raises two interrupt lines: one for finished transfers and one for errors. A parameter selects a big-endian register model, in which narrow accesses are address-swizzled so that each byte or halfword reaches the intended register.

Top module: `dmacr_bank`

## Requirements
- R1: After reset, every channel vector and the control register are zero. All reads return zero, and all outputs are low.
- R2: A word write at byte offset 0x0C loads the request-enable vector. A word write at 0x14 loads the error-interrupt-enable vector. Both read back unchanged, and the request-enable vector drives the `req_enable` output.
- R3: The control word at offset 0x00 keeps only three bits: bit 2 (round-robin channel arbitration, `arb_rr_chan`), bit 3 (round-robin group arbitration, `arb_rr_group`) and bit 5 (`halt`). Every other bit reads as zero.
- R4: A byte write to one of the command offsets sets or clears one channel bit. The offsets are 0x18 clear error-interrupt-enable, 0x19 set error-interrupt-enable, 0x1A clear request-enable and 0x1B set request-enable. The channel is given by bits 4:0 of the byte, and bits 7:5 are ignored.
- R5: Reads of the command words at 0x18 and 0x1C return zero.
- R6: A high bit n on `evt_done` sets bit n of the interrupt-pending vector (offset 0x24). A high bit n on `evt_err` sets bit n of the error-pending vector (offset 0x2C). A set bit stays set until it is cleared, either by a command byte (0x1F clears interrupt-pending, 0x1E clears error-pending) or by a word write with that bit at 1 (write-one-to-clear).
- R7: When an event sets a pending bit in the same cycle that software clears that bit, the bit ends up set.
- R8: `irq_xfer` is high whenever any interrupt-pending bit is set. `irq_err` is high whenever an error-pending bit is set and the same channel's error-interrupt-enable bit is also set.
- R9: A command byte at 0x1D with channel n raises bit n of `start_pulse`. A command byte at 0x1C raises bit n of `done_clear`. Each pulse lasts exactly the one cycle after the write.
- R10: With `BIG_ENDIAN` set, a byte access uses address XOR 3 and a halfword access uses address XOR 2. Word accesses are not swizzled.
- R11: Halfword (`bus_size`=1) and byte (`bus_size`=0) writes change only their own lanes. Narrow reads return the addressed lane right-aligned, with the upper bits zero.
- R12: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R13: In a wider write to a command word, every enabled byte lane acts as its own command. Lane k of the word at 0x18 or 0x1C is the command at that word's offset plus k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write value, right-aligned |
| bus_rdata | output | 32 | Read value, right-aligned, registered |
| evt_done | input | NCH | Per-channel major-loop completion event |
| evt_err | input | NCH | Per-channel error event |
| req_enable | output | NCH | Hardware request enable per channel |
| start_pulse | output | NCH | Software start pulse per channel |
| done_clear | output | NCH | Done-flag clear pulse per channel |
| arb_rr_chan | output | 1 | Round-robin channel arbitration enable |
| arb_rr_group | output | 1 | Round-robin group arbitration enable |
| halt | output | 1 | Engine halt |
| irq_xfer | output | 1 | Transfer interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
A write or an event sampled at a rising edge changes the vectors, `req_enable`, the control outputs and both interrupt lines at that same edge. So the bench drives on the falling edge and checks these results at the next falling edge. `start_pulse` and `done_clear` are high only between that edge and the following one. The bench therefore samples them at the first falling edge after the write and again one cycle later, when they must be zero. Read data is registered at the edge that samples the request, and the bench captures it at the next falling edge, before any later access can replace it.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
   // command byte carries the channel number in its low bits
   localparam int CMD_IDX_W = 5;

   // word indices (byte offset / 4) of the registers
   localparam int WIX_CTRL   = 0;
   localparam int WIX_REQ    = 3;
   localparam int WIX_EIE    = 5;
   localparam int WIX_CMD_LO = 6;
   localparam int WIX_CMD_HI = 7;
   localparam int WIX_INT    = 9;
   localparam int WIX_ERR    = 11;

   // command position = byte offset minus 0x18; the order is decoded by lane
   typedef enum logic [2:0] {
      CMD_CLR_EIE   = 3'd0,
      CMD_SET_EIE   = 3'd1,
      CMD_CLR_REQ   = 3'd2,
      CMD_SET_REQ   = 3'd3,
      CMD_CLR_DONE  = 3'd4,
      CMD_SET_START = 3'd5,
      CMD_CLR_ERR   = 3'd6,
      CMD_CLR_INT   = 3'd7
   } cmd_e;

   localparam int CTRL_RR_CHAN = 2;
   localparam int CTRL_RR_GRP  = 3;
   localparam int CTRL_HALT    = 5;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;
endpackage

// File: rtl/dmacr_lane_map.sv
module dmacr_lane_map
   import dmacr_pkg::*;
#(
   parameter int AW         = 6,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size,
   output logic [AW-3:0] word_idx,
   output logic [1:0]    lane,
   output logic [3:0]    be
);
   logic [1:0]    swz;
   logic [AW-1:0] eff;

   generate
      if (BIG_ENDIAN) begin : g_big
         always_comb begin
            case (size)
               SZ_BYTE: swz = 2'b11;
               SZ_HALF: swz = 2'b10;
               default: swz = 2'b00;
            endcase
         end
      end else begin : g_little
         assign swz = 2'b00;
      end
   endgenerate

   assign eff      = addr ^ {{(AW-2){1'b0}}, swz};
   assign word_idx = eff[AW-1:2];

   always_comb begin
      case (size)
         SZ_BYTE: begin
            lane = eff[1:0];
            be   = 4'b0001 << eff[1:0];
         end
         SZ_HALF: begin
            lane = {eff[1], 1'b0};
            be   = 4'b0011 << {eff[1], 1'b0};
         end
         default: begin
            lane = 2'b00;
            be   = 4'b1111;
         end
      endcase
   end
endmodule

// File: rtl/dmacr_cmd_decode.sv
module dmacr_cmd_decode
   import dmacr_pkg::*;
#(
   parameter int NCH = 32
) (
   input  logic                      wr_lo,
   input  logic                      wr_hi,
   input  logic [3:0]                be,
   input  logic [3:0][CMD_IDX_W-1:0] idx,
   output logic [7:0][NCH-1:0]       cmd_vec
);
   localparam logic [NCH-1:0] ONE = NCH'(1);

   generate
      for (genvar c = 0; c < 8; c++) begin : g_cmd
         localparam int LANE = c % 4;
         logic hit;
         if (c < 4) begin : g_lo
            assign hit = wr_lo & be[LANE];
         end else begin : g_hi
            assign hit = wr_hi & be[LANE];
         end
         // an index at or above NCH shifts the bit out: ignored
         assign cmd_vec[c] = hit ? (ONE << idx[LANE]) : '0;
      end
   endgenerate
endmodule

// File: rtl/dmacr_vec_reg.sv
module dmacr_vec_reg #(
   parameter int NCH = 32,
   parameter bit W1C = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_hit,
   input  logic [3:0]     be,
   input  logic [31:0]    wd_al,
   input  logic [NCH-1:0] sw_set,
   input  logic [NCH-1:0] sw_clr,
   input  logic [NCH-1:0] hw_set,
   output logic [NCH-1:0] q
);
   logic [31:0]    mask32;
   logic [NCH-1:0] mask;
   logic [NCH-1:0] data;
   logic [NCH-1:0] after_wr;
   logic [NCH-1:0] nxt;

   assign mask32 = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   assign mask   = mask32[NCH-1:0];
   assign data   = wd_al[NCH-1:0];

   generate
      if (W1C) begin : g_w1c
         assign after_wr = wr_hit ? (q & ~(mask & data)) : q;
      end else begin : g_rw
         assign after_wr = wr_hit ? ((q & ~mask) | (data & mask)) : q;
      end
   endgenerate

   // hardware set applied last: an event beats a same-cycle clear
   assign nxt = ((after_wr & ~sw_clr) | sw_set) | hw_set;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/dmacr_bank.sv
module dmacr_bank
   import dmacr_pkg::*;
#(
   parameter int NCH        = 32,
   parameter int AW         = 6,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_valid,
   input  logic           bus_write,
   input  logic [AW-1:0]  bus_addr,
   input  logic [1:0]     bus_size,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   input  logic [NCH-1:0] evt_done,
   input  logic [NCH-1:0] evt_err,
   output logic [NCH-1:0] req_enable,
   output logic [NCH-1:0] start_pulse,
   output logic [NCH-1:0] done_clear,
   output logic           arb_rr_chan,
   output logic           arb_rr_group,
   output logic           halt,
   output logic           irq_xfer,
   output logic           irq_err
);
   localparam int          WW        = AW - 2;
   localparam logic [WW-1:0] IX_CTRL = WW'(WIX_CTRL);
   localparam logic [WW-1:0] IX_REQ  = WW'(WIX_REQ);
   localparam logic [WW-1:0] IX_EIE  = WW'(WIX_EIE);
   localparam logic [WW-1:0] IX_CLO  = WW'(WIX_CMD_LO);
   localparam logic [WW-1:0] IX_CHI  = WW'(WIX_CMD_HI);
   localparam logic [WW-1:0] IX_INT  = WW'(WIX_INT);
   localparam logic [WW-1:0] IX_ERR  = WW'(WIX_ERR);
   localparam logic [31:0] CTRL_MASK =
      (32'd1 << CTRL_RR_CHAN) | (32'd1 << CTRL_RR_GRP) | (32'd1 << CTRL_HALT);

   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("dmacr_bank: NCH must lie in 1..32");
      end
      if (AW < 6) begin : g_bad_aw
         $error("dmacr_bank: AW must be at least 6");
      end
   endgenerate

   logic [WW-1:0] word_idx;
   logic [1:0]    lane;
   logic [3:0]    be;
   logic          wr, rd;
   logic [31:0]   wd_al;
   logic [31:0]   be_mask32;

   dmacr_lane_map #(.AW(AW), .BIG_ENDIAN(BIG_ENDIAN)) u_map (
      .addr     (bus_addr),
      .size     (bus_size),
      .word_idx (word_idx),
      .lane     (lane),
      .be       (be)
   );

   assign wr        = bus_valid & bus_write;
   assign rd        = bus_valid & ~bus_write;
   assign wd_al     = bus_wdata << {lane, 3'b000};
   assign be_mask32 = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

   // ---- command bytes ----
   logic [3:0][CMD_IDX_W-1:0] cmd_idx;
   logic [7:0][NCH-1:0]       cmd_vec;

   generate
      for (genvar k = 0; k < 4; k++) begin : g_idx
         assign cmd_idx[k] = wd_al[8*k +: CMD_IDX_W];
      end
   endgenerate

   dmacr_cmd_decode #(.NCH(NCH)) u_cmd (
      .wr_lo   (wr && word_idx == IX_CLO),
      .wr_hi   (wr && word_idx == IX_CHI),
      .be      (be),
      .idx     (cmd_idx),
      .cmd_vec (cmd_vec)
   );

   // ---- channel vectors ----
   logic [NCH-1:0] req_q, eie_q, int_q, err_q;
   logic [NCH-1:0] no_evt;
   assign no_evt = '0;

   dmacr_vec_reg #(.NCH(NCH), .W1C(1'b0)) u_req (
      .clk (clk), .rst_n (rst_n),
      .wr_hit (wr && word_idx == IX_REQ), .be (be), .wd_al (wd_al),
      .sw_set (cmd_vec[CMD_SET_REQ]), .sw_clr (cmd_vec[CMD_CLR_REQ]),
      .hw_set (no_evt), .q (req_q)
   );

   dmacr_vec_reg #(.NCH(NCH), .W1C(1'b0)) u_eie (
      .clk (clk), .rst_n (rst_n),
      .wr_hit (wr && word_idx == IX_EIE), .be (be), .wd_al (wd_al),
      .sw_set (cmd_vec[CMD_SET_EIE]), .sw_clr (cmd_vec[CMD_CLR_EIE]),
      .hw_set (no_evt), .q (eie_q)
   );

   dmacr_vec_reg #(.NCH(NCH), .W1C(1'b1)) u_int (
      .clk (clk), .rst_n (rst_n),
      .wr_hit (wr && word_idx == IX_INT), .be (be), .wd_al (wd_al),
      .sw_set (no_evt), .sw_clr (cmd_vec[CMD_CLR_INT]),
      .hw_set (evt_done), .q (int_q)
   );

   dmacr_vec_reg #(.NCH(NCH), .W1C(1'b1)) u_err (
      .clk (clk), .rst_n (rst_n),
      .wr_hit (wr && word_idx == IX_ERR), .be (be), .wd_al (wd_al),
      .sw_set (no_evt), .sw_clr (cmd_vec[CMD_CLR_ERR]),
      .hw_set (evt_err), .q (err_q)
   );

   // ---- global control and engine pulses ----
   logic [31:0]    ctrl_q;
   logic [31:0]    ctrl_m;
   logic [NCH-1:0] start_q, dclr_q;

   assign ctrl_m = be_mask32 & CTRL_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         start_q <= '0;
         dclr_q  <= '0;
      end else begin
         if (wr && word_idx == IX_CTRL)
            ctrl_q <= (ctrl_q & ~ctrl_m) | (wd_al & ctrl_m);
         start_q <= cmd_vec[CMD_SET_START];
         dclr_q  <= cmd_vec[CMD_CLR_DONE];
      end
   end

   // ---- read path ----
   logic [31:0] rd_word, rd_shift, rd_val, rdata_q;

   always_comb begin
      case (word_idx)
         IX_CTRL: rd_word = ctrl_q;
         IX_REQ:  rd_word = 32'(req_q);
         IX_EIE:  rd_word = 32'(eie_q);
         IX_INT:  rd_word = 32'(int_q);
         IX_ERR:  rd_word = 32'(err_q);
         default: rd_word = 32'd0;
      endcase
   end

   assign rd_shift = rd_word >> {lane, 3'b000};

   always_comb begin
      case (bus_size)
         SZ_BYTE: rd_val = {24'd0, rd_shift[7:0]};
         SZ_HALF: rd_val = {16'd0, rd_shift[15:0]};
         default: rd_val = rd_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rd_val;
   end

   assign bus_rdata    = rdata_q;
   assign req_enable   = req_q;
   assign start_pulse  = start_q;
   assign done_clear   = dclr_q;
   assign arb_rr_chan  = ctrl_q[CTRL_RR_CHAN];
   assign arb_rr_group = ctrl_q[CTRL_RR_GRP];
   assign halt         = ctrl_q[CTRL_HALT];
   assign irq_xfer     = |int_q;
   assign irq_err      = |(err_q & eie_q);
endmodule

// File: rtl/dmacr_bank_chk.sv
module dmacr_bank_chk #(
   parameter int NCH = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_valid,
   input logic           bus_write,
   input logic [31:0]    bus_rdata,
   input logic [NCH-1:0] evt_done,
   input logic [NCH-1:0] evt_err,
   input logic [NCH-1:0] int_q,
   input logic [NCH-1:0] err_q,
   input logic [NCH-1:0] req_enable,
   input logic [NCH-1:0] start_pulse,
   input logic [NCH-1:0] done_clear,
   input logic           halt,
   input logic           irq_xfer
);
   // R6 / R7: an event always leaves its pending bit set
   a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_done) |=> ((int_q & $past(evt_done)) == $past(evt_done)));
   a_r7_err_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_err) |=> ((err_q & $past(evt_err)) == $past(evt_err)));
   // R6: pending bits only drop after a bus write
   a_r6_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> ((int_q & $past(int_q)) == $past(int_q)));
   // R9: pulses follow a write and name one channel each
   a_r9_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_pulse));
   a_r9_dclr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_clear));
   a_r9_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|start_pulse) |-> $past(bus_valid && bus_write));
   // R2 / R3: configuration changes only through writes
   a_r2_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(req_enable));
   a_r3_halt_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(halt));
   // R8: transfer interrupt rises only after a completion event
   a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_xfer) |-> $past(|evt_done));
   // R12: read data holds between reads
   a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind dmacr_bank dmacr_bank_chk #(.NCH(NCH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_valid   (bus_valid),
   .bus_write   (bus_write),
   .bus_rdata   (bus_rdata),
   .evt_done    (evt_done),
   .evt_err     (evt_err),
   .int_q       (int_q),
   .err_q       (err_q),
   .req_enable  (req_enable),
   .start_pulse (start_pulse),
   .done_clear  (done_clear),
   .halt        (halt),
   .irq_xfer    (irq_xfer)
);

// File: tb/tb_dmacr_bank.sv
module tb_dmacr_bank;
   localparam int NCH = 32;
   localparam int AW  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          v0 = 1'b0, v1 = 1'b0;
   logic          bwr = 1'b0;
   logic [AW-1:0] baddr = '0;
   logic [1:0]    bsize = 2'd0;
   logic [31:0]   bwd = '0;
   logic [31:0]   rd0, rd1;
   logic [31:0]   evd = '0, eve = '0;
   logic [31:0]   zero_ev = '0;

   logic [31:0] req0, sp0, dc0, req1, sp1, dc1;
   logic rrc0, rrg0, hlt0, ix0, ie0, rrc1, rrg1, hlt1, ix1, ie1;

   dmacr_bank #(.NCH(NCH), .AW(AW), .BIG_ENDIAN(1'b0)) dut (
      .clk (clk), .rst_n (rst_n), .bus_valid (v0), .bus_write (bwr),
      .bus_addr (baddr), .bus_size (bsize), .bus_wdata (bwd), .bus_rdata (rd0),
      .evt_done (evd), .evt_err (eve), .req_enable (req0),
      .start_pulse (sp0), .done_clear (dc0), .arb_rr_chan (rrc0),
      .arb_rr_group (rrg0), .halt (hlt0), .irq_xfer (ix0), .irq_err (ie0)
   );

   dmacr_bank #(.NCH(NCH), .AW(AW), .BIG_ENDIAN(1'b1)) dut_be (
      .clk (clk), .rst_n (rst_n), .bus_valid (v1), .bus_write (bwr),
      .bus_addr (baddr), .bus_size (bsize), .bus_wdata (bwd), .bus_rdata (rd1),
      .evt_done (zero_ev), .evt_err (zero_ev), .req_enable (req1),
      .start_pulse (sp1), .done_clear (dc1), .arb_rr_chan (rrc1),
      .arb_rr_group (rrg1), .halt (hlt1), .irq_xfer (ix1), .irq_err (ie1)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // write; events in the same cycle; results visible on return
   task automatic bus_wr(input bit sel, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input logic [31:0] dm, input logic [31:0] em);
      @(negedge clk);
      v0 = !sel; v1 = sel; bwr = 1'b1;
      baddr = a[AW-1:0]; bsize = sz; bwd = d; evd = dm; eve = em;
      @(negedge clk);
      v0 = 1'b0; v1 = 1'b0; bwr = 1'b0; evd = '0; eve = '0;
   endtask

   task automatic bus_rd(input bit sel, input logic [7:0] a, input logic [1:0] sz,
                         output logic [31:0] d);
      @(negedge clk);
      v0 = !sel; v1 = sel; bwr = 1'b0; baddr = a[AW-1:0]; bsize = sz;
      @(negedge clk);
      d = sel ? rd1 : rd0;
      v0 = 1'b0; v1 = 1'b0;
   endtask

   task automatic pulse_evt(input logic [31:0] dm, input logic [31:0] em);
      @(negedge clk);
      evd = dm; eve = em;
      @(negedge clk);
      evd = '0; eve = '0;
   endtask

   task automatic t_reset();
      logic [31:0] r;
      chk("R1 req_enable", req0, 0);
      chk("R1 outputs", {26'd0, rrc0, rrg0, hlt0, ix0, ie0, |sp0}, 0);
      bus_rd(0, 8'h00, 2, r); chk("R1 ctrl", r, 0);
      bus_rd(0, 8'h14, 2, r); chk("R1 eie", r, 0);
      bus_rd(0, 8'h24, 2, r); chk("R1 int", r, 0);
      bus_rd(0, 8'h2C, 2, r); chk("R1 err", r, 0);
      bus_rd(1, 8'h0C, 2, r); chk("R1 be req", r, 0);
   endtask

   task automatic t_word();
      logic [31:0] r;
      bus_wr(0, 8'h0C, 2, 32'hA5A5_0F0F, 0, 0);
      chk("R2 req port", req0, 32'hA5A5_0F0F);
      bus_rd(0, 8'h0C, 2, r); chk("R2/R12 req read", r, 32'hA5A5_0F0F);
      bus_wr(0, 8'h14, 2, 32'h0000_00FF, 0, 0);
      bus_rd(0, 8'h14, 2, r); chk("R2 eie read", r, 32'h0000_00FF);
   endtask

   task automatic t_ctrl();
      logic [31:0] r;
      bus_wr(0, 8'h00, 2, 32'hFFFF_FFFF, 0, 0);
      bus_rd(0, 8'h00, 2, r); chk("R3 ctrl mask", r, 32'h2C);
      chk("R3 ctrl outs", {29'd0, rrc0, rrg0, hlt0}, 3'b111);
      bus_wr(0, 8'h00, 2, 32'h0000_0004, 0, 0);
      chk("R3 ctrl outs 2", {29'd0, rrc0, rrg0, hlt0}, 3'b100);
   endtask

   task automatic t_cmd();
      logic [31:0] r;
      bus_wr(0, 8'h0C, 2, 0, 0, 0);
      bus_wr(0, 8'h1B, 0, 32'hE3, 0, 0);
      chk("R4 set req ch3 upper bits ignored", req0, 32'h8);
      bus_wr(0, 8'h1B, 0, 32'h1F, 0, 0);
      chk("R4 set req ch31", req0, 32'h8000_0008);
      bus_wr(0, 8'h1A, 0, 32'h03, 0, 0);
      chk("R4 clr req ch3", req0, 32'h8000_0000);
      bus_wr(0, 8'h19, 0, 32'd20, 0, 0);
      bus_wr(0, 8'h18, 0, 32'd0, 0, 0);
      bus_rd(0, 8'h14, 2, r); chk("R4 eie set/clr", r, 32'h0010_00FE);
      bus_rd(0, 8'h18, 2, r); chk("R5 cmd word lo reads 0", r, 0);
      bus_rd(0, 8'h1D, 0, r); chk("R5 cmd byte reads 0", r, 0);
   endtask

   task automatic t_start();
      bus_wr(0, 8'h1D, 0, 32'd9, 0, 0);
      chk("R9 start pulse", sp0, 32'h200);
      @(negedge clk);
      chk("R9 start one cycle", sp0, 0);
      bus_wr(0, 8'h1C, 0, 32'd4, 0, 0);
      chk("R9 done clear", dc0, 32'h10);
      @(negedge clk);
      chk("R9 done clear one cycle", dc0, 0);
   endtask

   task automatic t_events();
      logic [31:0] r;
      bus_wr(0, 8'h14, 2, 0, 0, 0);
      pulse_evt(32'h4, 32'h20);
      chk("R8 irq pair", {30'd0, ix0, ie0}, 2'b10);
      bus_rd(0, 8'h24, 2, r); chk("R6 int pending", r, 32'h4);
      bus_rd(0, 8'h2C, 2, r); chk("R6 err pending", r, 32'h20);
      bus_wr(0, 8'h19, 0, 32'd5, 0, 0);
      chk("R8 irq_err enabled", {31'd0, ie0}, 1);
      bus_wr(0, 8'h1F, 0, 32'd2, 0, 0);
      chk("R8 irq_xfer cleared", {31'd0, ix0}, 0);
      bus_rd(0, 8'h24, 2, r); chk("R6 int cmd clear", r, 0);
      bus_wr(0, 8'h2C, 2, 32'h20, 0, 0);
      chk("R8 irq_err after w1c", {31'd0, ie0}, 0);
      bus_rd(0, 8'h2C, 2, r); chk("R6 err w1c", r, 0);
   endtask

   task automatic t_race();
      logic [31:0] r;
      pulse_evt(32'h40, 0);
      bus_wr(0, 8'h1F, 0, 32'd6, 32'h40, 0);
      bus_rd(0, 8'h24, 2, r); chk("R7 done beats clear", r, 32'h40);
      pulse_evt(0, 32'h2);
      bus_wr(0, 8'h1E, 0, 32'd1, 0, 32'h2);
      bus_rd(0, 8'h2C, 2, r); chk("R7 err beats clear", r, 32'h2);
      bus_wr(0, 8'h1E, 0, 32'd1, 0, 0);
      bus_wr(0, 8'h1F, 0, 32'd6, 0, 0);
      bus_rd(0, 8'h2C, 2, r); chk("R6 err cleared", r, 0);
      bus_rd(0, 8'h24, 2, r); chk("R6 int cleared", r, 0);
   endtask

   task automatic t_multilane();
      logic [31:0] r;
      bus_wr(0, 8'h14, 2, 32'h8, 0, 0);
      bus_wr(0, 8'h18, 2, 32'h011F_0203, 0, 0);
      chk("R13 req lanes", req0, 32'h2);
      bus_rd(0, 8'h14, 2, r); chk("R13 eie lanes", r, 32'h4);
   endtask

   task automatic t_half();
      logic [31:0] r;
      bus_wr(0, 8'h0E, 1, 32'h0000_BEEF, 0, 0);
      chk("R11 half write", req0, 32'hBEEF_0002);
      bus_wr(0, 8'h0D, 0, 32'h55, 0, 0);
      chk("R11 byte write", req0, 32'hBEEF_5502);
      bus_rd(0, 8'h0E, 1, r); chk("R11 half read", r, 32'hBEEF);
      bus_rd(0, 8'h0F, 0, r); chk("R11 byte read", r, 32'hBE);
   endtask

   task automatic t_be();
      logic [31:0] r;
      bus_wr(1, 8'h18, 0, 32'd4, 0, 0);
      chk("R10 be byte cmd swizzle", req1, 32'h10);
      bus_wr(1, 8'h0C, 1, 32'h1234, 0, 0);
      chk("R10 be half swizzle", req1, 32'h1234_0010);
      bus_rd(1, 8'h0C, 2, r); chk("R10 be word read", r, 32'h1234_0010);
      bus_rd(1, 8'h0F, 0, r); chk("R10 be byte read", r, 32'h10);
      bus_rd(1, 8'h0E, 1, r); chk("R10 be half read", r, 32'h0010);
      chk("R10 le instance untouched", req0, 32'hBEEF_5502);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_word();
      t_ctrl();
      t_cmd();
      t_start();
      t_events();
      t_race();
      t_multilane();
      t_half();
      t_be();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule